// File: doc/BRIEF.md
# Divergent Lane Group Scheduler

This block decides the order in which the lanes of one SIMD batch run when each lane keeps its own program counter. A start pulse loads a per-lane program counter vector and a mask of active lanes. The block then works in rounds over a pending mask. In each step it takes the lowest-numbered pending lane as the anchor and collects every pending lane whose program counter equals the anchor's. It offers that group on a valid/ready issue port together with the shared program counter.

Once the group is accepted, the execution side reports every retired instruction. Each report carries the group's next program counter and four flags: branch, barrier, fetch and exit. The next program counter is written back into the lanes of the group. A slice ends on a barrier, a fetch or an exit. It also ends on a branch, but only after the slice's instruction budget has run out, so a group is only broken up at a control-flow point. When a round has drained the pending mask, the lanes that have not exited form the next round. When no lanes are left, the block raises done.

Top module: `lane_group_sched`

## Requirements
- R1: After reset, issue_valid, run_active and done are all low.
- R2: A start pulse is taken only while the block is idle. It loads the pending and live lane sets from start_mask and lane i's program counter from start_pcs bits [i*PC_W +: PC_W]. A start pulse during a batch has no effect.
- R3: The anchor of each group is the lowest-numbered pending lane, and issue_pc equals that lane's current program counter.
- R4: issue_mask holds every pending lane whose program counter equals the anchor's. Those lanes leave the pending set when the group is accepted.
- R5: While issue_valid is high and issue_ready is low, issue_valid, issue_mask and issue_pc stay unchanged.
- R6: Each retire report writes ret_next_pc into the program counter of every lane of the running group. A report with ret_sync or ret_fetch set ends the slice, and run_active falls one clock later.
- R7: A slice has a budget of TIMEOUT retire reports. A branch report ends the slice only if at least TIMEOUT reports came before it in that slice. A branch within the budget, or a non-branch report after the budget, keeps the group running.
- R8: A report with ret_exit set ends the slice and retires the group's lanes for the rest of the batch. Exit takes precedence when sync or fetch is set in the same report.
- R9: When the pending set is empty and lanes are still live, the pending set is reloaded from the live lanes and a new round starts.
- R10: done goes high once no live lanes remain, including right after a start with an empty mask. It goes low on the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a batch (taken only when idle) |
| start_mask | input | N_LANES | Lanes active in the new batch |
| start_pcs | input | N_LANES*PC_W | Initial program counter per lane |
| issue_valid | output | 1 | A group is offered |
| issue_ready | input | 1 | Execution side accepts the group |
| issue_mask | output | N_LANES | Predicate mask of the offered group |
| issue_pc | output | PC_W | Shared program counter of the group |
| run_active | output | 1 | An accepted group is running |
| ret_valid | input | 1 | One instruction of the running group retired |
| ret_next_pc | input | PC_W | Next program counter of the group |
| ret_branch | input | 1 | Retired instruction was control flow |
| ret_sync | input | 1 | Retired instruction was a barrier |
| ret_fetch | input | 1 | Retired instruction was a fetch |
| ret_exit | input | 1 | Group lanes finished the program |
| done | output | 1 | Batch complete, all lanes exited |

## Verification
Two events can land on the same retire report. One is the report that uses up the instruction budget arriving with the branch flag set. That report must not end the slice, because the budget only counts as spent after it. The bench sends three branch reports into a budget of three and checks that run_active stays high. It then sends a non-branch report followed by a branch report and checks that run_active falls only after the last one. The other case is exit and barrier flags arriving together. The bench raises both on one report, then checks that done is raised and that those lanes are never issued again.

// File: rtl/lgs_pkg.sv
package lgs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PICK  = 2'd1,
      ST_ISSUE = 2'd2,
      ST_RUN   = 2'd3
   } lgs_state_e;
endpackage

// File: rtl/lgs_lowest_enc.sv
module lgs_lowest_enc #(
   parameter int N_LANES   = 8,
   parameter int ENC_STYLE = 0,
   localparam int IW       = $clog2(N_LANES)
) (
   input  logic [N_LANES-1:0] req,
   output logic [IW-1:0]      idx
);
   generate
      if (ENC_STYLE == 0) begin : g_scan
         always_comb begin
            idx = '0;
            for (int i = N_LANES - 1; i >= 0; i--) begin
               if (req[i]) idx = IW'(i);
            end
         end
      end else begin : g_isolate
         logic [N_LANES-1:0] lowbit;
         assign lowbit = req & (~req + N_LANES'(1));
         always_comb begin
            idx = '0;
            for (int i = 0; i < N_LANES; i++) begin
               if (lowbit[i]) idx = idx | IW'(i);
            end
         end
      end
      if (ENC_STYLE != 0 && ENC_STYLE != 1) begin : g_bad_style
         $error("lgs_lowest_enc: ENC_STYLE must be 0 or 1");
      end
   endgenerate
endmodule

// File: rtl/lgs_pc_file.sv
module lgs_pc_file #(
   parameter int N_LANES = 8,
   parameter int PC_W    = 16,
   localparam int IW     = $clog2(N_LANES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [N_LANES*PC_W-1:0] load_pcs,
   input  logic                    wr_en,
   input  logic [N_LANES-1:0]      wr_mask,
   input  logic [PC_W-1:0]         wr_pc,
   input  logic [IW-1:0]           rd_idx,
   output logic [PC_W-1:0]         rd_pc,
   output logic [N_LANES-1:0]      eq_vec
);
   logic [PC_W-1:0] lane_pc [N_LANES];

   assign rd_pc = lane_pc[rd_idx];

   generate
      for (genvar g = 0; g < N_LANES; g++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_pc[g] <= '0;
            end else if (load) begin
               lane_pc[g] <= load_pcs[g*PC_W +: PC_W];
            end else if (wr_en && wr_mask[g]) begin
               lane_pc[g] <= wr_pc;
            end
         end
         assign eq_vec[g] = (lane_pc[g] == rd_pc);
      end
   endgenerate
endmodule

// File: rtl/lgs_slice_timer.sv
module lgs_slice_timer #(
   parameter int TIMEOUT = 16,
   localparam int CW     = $clog2(TIMEOUT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   input  logic tick,
   output logic expired
);
   logic [CW-1:0] cnt_q;
   logic          exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (reload) begin
         cnt_q <= CW'(TIMEOUT);
         exp_q <= 1'b0;
      end else if (tick && cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
         if (cnt_q == CW'(1)) exp_q <= 1'b1;
      end
   end

   assign expired = exp_q;
endmodule

// File: rtl/lane_group_sched.sv
module lane_group_sched
   import lgs_pkg::*;
#(
   parameter int N_LANES   = 8,
   parameter int PC_W      = 16,
   parameter int TIMEOUT   = 16,
   parameter int ENC_STYLE = 0,
   localparam int IW       = $clog2(N_LANES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [N_LANES-1:0]      start_mask,
   input  logic [N_LANES*PC_W-1:0] start_pcs,
   output logic                    issue_valid,
   input  logic                    issue_ready,
   output logic [N_LANES-1:0]      issue_mask,
   output logic [PC_W-1:0]         issue_pc,
   output logic                    run_active,
   input  logic                    ret_valid,
   input  logic [PC_W-1:0]         ret_next_pc,
   input  logic                    ret_branch,
   input  logic                    ret_sync,
   input  logic                    ret_fetch,
   input  logic                    ret_exit,
   output logic                    done
);
   generate
      if (N_LANES < 2)  begin : g_chk_lanes $error("N_LANES must be at least 2"); end
      if (PC_W < 1)     begin : g_chk_pcw   $error("PC_W must be at least 1"); end
      if (TIMEOUT < 1)  begin : g_chk_to    $error("TIMEOUT must be at least 1"); end
   endgenerate

   lgs_state_e          st_q;
   logic [N_LANES-1:0]  pend_q, alive_q, grp_q;
   logic [PC_W-1:0]     gpc_q;
   logic                done_q;

   logic [IW-1:0]       anc_idx;
   logic [PC_W-1:0]     anc_pc;
   logic [N_LANES-1:0]  eq_vec, form_mask;
   logic                take, hs, ret_ok, expired, slice_end;

   assign take      = (st_q == ST_IDLE) && start;
   assign hs        = (st_q == ST_ISSUE) && issue_ready;
   assign ret_ok    = (st_q == ST_RUN) && ret_valid;
   assign slice_end = ret_ok && (ret_exit || ret_sync || ret_fetch || (ret_branch && expired));
   assign form_mask = pend_q & eq_vec;

   lgs_lowest_enc #(.N_LANES(N_LANES), .ENC_STYLE(ENC_STYLE)) enc_i (
      .req (pend_q),
      .idx (anc_idx)
   );

   lgs_pc_file #(.N_LANES(N_LANES), .PC_W(PC_W)) pcf_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (take),
      .load_pcs (start_pcs),
      .wr_en    (ret_ok),
      .wr_mask  (grp_q),
      .wr_pc    (ret_next_pc),
      .rd_idx   (anc_idx),
      .rd_pc    (anc_pc),
      .eq_vec   (eq_vec)
   );

   lgs_slice_timer #(.TIMEOUT(TIMEOUT)) tmr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .reload  (hs),
      .tick    (ret_ok),
      .expired (expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         pend_q  <= '0;
         alive_q <= '0;
         grp_q   <= '0;
         gpc_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  pend_q  <= start_mask;
                  alive_q <= start_mask;
                  done_q  <= 1'b0;
                  st_q    <= ST_PICK;
               end
            end
            ST_PICK: begin
               if (pend_q == '0) begin
                  if (alive_q == '0) begin
                     done_q <= 1'b1;
                     st_q   <= ST_IDLE;
                  end else begin
                     pend_q <= alive_q;
                  end
               end else begin
                  grp_q <= form_mask;
                  gpc_q <= anc_pc;
                  st_q  <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (issue_ready) begin
                  pend_q <= pend_q & ~grp_q;
                  st_q   <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (ret_valid) begin
                  gpc_q <= ret_next_pc;
                  if (ret_exit) alive_q <= alive_q & ~grp_q;
                  if (slice_end) st_q <= ST_PICK;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign issue_valid = (st_q == ST_ISSUE);
   assign issue_mask  = grp_q;
   assign issue_pc    = gpc_q;
   assign run_active  = (st_q == ST_RUN);
   assign done        = done_q;
endmodule

// File: rtl/lane_group_sched_chk.sv
module lane_group_sched_chk #(
   parameter int N_LANES = 8,
   parameter int PC_W    = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               issue_valid,
   input logic               issue_ready,
   input logic [N_LANES-1:0] issue_mask,
   input logic [PC_W-1:0]    issue_pc,
   input logic               run_active,
   input logic               done,
   input logic [N_LANES-1:0] pend_q
);
   AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_ready) |=> (issue_valid && $stable(issue_mask) && $stable(issue_pc))); // R5

   AST_GROUP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (issue_mask != '0)); // R4

   AST_GROUP_LEAVES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready) |=> ((pend_q & $past(issue_mask)) == '0)); // R4

   AST_OFFER_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> ((issue_mask & ~pend_q) == '0)); // R4

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!issue_valid && !run_active)); // R10

   AST_NO_OFFER_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_valid && run_active)); // R6
endmodule

bind lane_group_sched lane_group_sched_chk #(.N_LANES(N_LANES), .PC_W(PC_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .issue_ready (issue_ready),
   .issue_mask  (issue_mask),
   .issue_pc    (issue_pc),
   .run_active  (run_active),
   .done        (done),
   .pend_q      (pend_q)
);

// File: tb/lane_group_sched_tb_top.sv
module lane_group_sched_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int PW = 8;
   localparam int TO = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [N-1:0]  start_mask = '0;
   logic [N*PW-1:0] start_pcs = '0;
   logic          issue_valid, run_active, done;
   logic          issue_ready = 1'b0;
   logic [N-1:0]  issue_mask;
   logic [PW-1:0] issue_pc;
   logic          ret_valid = 1'b0;
   logic [PW-1:0] ret_next_pc = '0;
   logic          ret_branch = 1'b0, ret_sync = 1'b0, ret_fetch = 1'b0, ret_exit = 1'b0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_group_sched #(.N_LANES(N), .PC_W(PW), .TIMEOUT(TO), .ENC_STYLE(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .start_mask(start_mask), .start_pcs(start_pcs),
      .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_mask(issue_mask),
      .issue_pc(issue_pc), .run_active(run_active), .ret_valid(ret_valid),
      .ret_next_pc(ret_next_pc), .ret_branch(ret_branch), .ret_sync(ret_sync),
      .ret_fetch(ret_fetch), .ret_exit(ret_exit), .done(done)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         summary();
      end
   end

   task automatic do_start(input logic [N-1:0] m, input logic [N*PW-1:0] pcs);
      start = 1'b1; start_mask = m; start_pcs = pcs;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_offer(output bit seen);
      seen = 0;
      for (int k = 0; k < 30; k++) begin
         if (issue_valid) begin seen = 1; break; end
         @(negedge clk);
      end
   endtask

   task automatic take_offer(input logic [N-1:0] em, input logic [PW-1:0] ep, input string req);
      bit seen;
      wait_offer(seen);
      check(seen, {req, " offer appears"}, 32'(seen), 1);
      check(issue_mask == em, {req, " mask"}, 32'(issue_mask), 32'(em));
      check(issue_pc == ep, {req, " pc"}, 32'(issue_pc), 32'(ep));
      issue_ready = 1'b1;
      @(negedge clk);
      issue_ready = 1'b0;
   endtask

   task automatic retire(input logic [PW-1:0] npc, input bit br, input bit sy, input bit fe, input bit ex);
      ret_valid = 1'b1; ret_next_pc = npc;
      ret_branch = br; ret_sync = sy; ret_fetch = fe; ret_exit = ex;
      @(negedge clk);
      ret_valid = 1'b0; ret_branch = 1'b0; ret_sync = 1'b0; ret_fetch = 1'b0; ret_exit = 1'b0;
   endtask

   task automatic wait_done(input string req);
      bit seen = 0;
      for (int k = 0; k < 10; k++) begin
         if (done) begin seen = 1; break; end
         if (issue_valid) break;
         @(negedge clk);
      end
      check(seen, {req, " done raised"}, 32'(seen), 1);
   endtask

   initial begin
      logic [N*PW-1:0] pcs;
      logic [PW-1:0]   mpc [N];
      logic [N-1:0]    pend, alive, grp;
      int              anc;

      repeat (3) @(negedge clk);
      // R1: reset state
      check(!issue_valid && !run_active && !done, "R1 reset outputs", {issue_valid, run_active, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!issue_valid && !run_active && !done, "R1 after release", {issue_valid, run_active, done}, 0);

      // R10: empty batch completes at once
      do_start('0, '0);
      wait_done("R10 empty start");

      // Sweep: every start mask, three program counter patterns
      for (int seed = 0; seed < 3; seed++) begin
         for (int m = 0; m < (1 << N); m++) begin
            for (int i = 0; i < N; i++) begin
               mpc[i] = PW'(8'h10 + ((i * (seed + 1) + seed) % 3));
               pcs[i*PW +: PW] = mpc[i];
            end
            do_start(N'(m), pcs);
            check(!done, "R10 done cleared by start", 32'(done), 0);
            pend = N'(m); alive = N'(m);
            while (alive != '0) begin
               if (pend == '0) pend = alive; // R9 new round
               anc = 0;
               for (int i = N - 1; i >= 0; i--) if (pend[i]) anc = i;
               grp = '0;
               for (int i = 0; i < N; i++) if (pend[i] && mpc[i] == mpc[anc]) grp[i] = 1'b1;
               take_offer(grp, mpc[anc], "R3 R4 R9 sweep");
               pend = pend & ~grp;
               if (mpc[anc] < 8'h20) begin
                  logic [PW-1:0] nx;
                  nx = mpc[anc] + 8'h10;
                  retire(nx, 0, 1, 0, 0); // R6 sync ends slice, pc written back
                  for (int i = 0; i < N; i++) if (grp[i]) mpc[i] = nx;
               end else begin
                  retire(mpc[anc], 0, 0, 0, 1); // R8
                  alive = alive & ~grp;
               end
            end
            wait_done("R10 sweep");
         end
      end

      // R5: offer held while not ready; R7 budget
      do_start(8'h0F, {N{8'h05}});
      begin
         bit seen;
         wait_offer(seen);
         check(seen, "R5 offer", 32'(seen), 1);
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(issue_valid && issue_mask == 8'h0F && issue_pc == 8'h05, "R5 held",
                  {issue_valid, issue_mask, issue_pc}, {1'b1, 8'h0F, 8'h05});
         end
      end
      take_offer(8'h0F, 8'h05, "R5 accept");
      retire(8'h06, 1, 0, 0, 0);
      check(run_active, "R7 branch within budget", 32'(run_active), 1);
      retire(8'h07, 1, 0, 0, 0);
      check(run_active, "R7 branch within budget", 32'(run_active), 1);
      retire(8'h08, 1, 0, 0, 0); // budget used up on this branch report
      check(run_active, "R7 last budget branch keeps running", 32'(run_active), 1);
      retire(8'h09, 0, 0, 0, 0);
      check(run_active, "R7 non-branch after budget", 32'(run_active), 1);
      retire(8'h0A, 1, 0, 0, 0);
      check(!run_active, "R7 branch after budget ends slice", 32'(run_active), 0);
      take_offer(8'h0F, 8'h0A, "R6 R9 reissue with written pc");
      // R8: exit together with sync
      retire(8'h0B, 0, 1, 0, 1);
      check(!run_active, "R8 exit ends slice", 32'(run_active), 0);
      wait_done("R8 exit over sync");

      // R2: start during a batch is ignored
      pcs = '0;
      pcs[0*PW +: PW] = 8'h01;
      pcs[1*PW +: PW] = 8'h02;
      do_start(8'h03, pcs);
      take_offer(8'h01, 8'h01, "R2 R3 first group");
      do_start(8'hFF, {N{8'h44}});
      check(run_active, "R2 start ignored while running", 32'(run_active), 1);
      retire(8'h01, 0, 0, 0, 1);
      take_offer(8'h02, 8'h02, "R2 batch unchanged by late start");
      retire(8'h02, 0, 0, 0, 1);
      wait_done("R2 batch end");

      // R6: fetch ends slice and writes pc
      pcs = '0;
      pcs[2*PW +: PW] = 8'h04;
      pcs[3*PW +: PW] = 8'h04;
      do_start(8'h0C, pcs);
      take_offer(8'h0C, 8'h04, "R3 R4 fetch group");
      retire(8'h33, 0, 0, 1, 0);
      check(!run_active, "R6 fetch ends slice", 32'(run_active), 0);
      take_offer(8'h0C, 8'h33, "R6 pc after fetch");
      retire(8'h34, 0, 0, 0, 1);
      wait_done("R6 batch end");

      summary();
   end
endmodule